// File: doc/BRIEF.md
# Configuration Access Proxy

This block lets a host processor perform one 32-bit read or write on the configuration space of a remote thread through a small set of memory-mapped registers. Software first programs the target word address and byte enables, the write data, the thread number and the direction. It then writes the command word with its busy bit set. The proxy raises a valid/ready request toward the remote side and waits for a one-cycle response pulse. For a read, it stores the returned word in a read-back register.

A watchdog is loaded from a programmable period when the transaction starts. If no response arrives in time, the watchdog closes the transaction. It then sets a timeout flag in the command word and a sticky timeout flag in the timeout control register. Software polls the busy bit to learn that the transaction has finished.

Top module: `cfg_xact_proxy`

## Requirements
- R1: After reset, the registers read as follows: revision (0x000) = 0x66C00100, timeout control (0x010) = 0x00000400, command A (0x100), command B (0x104), write data (0x108) and read data (0x140) = 0. Any other offset reads 0.
- R2: A read strobe returns the addressed word on host_rdata one cycle later. The layouts are:
  - Command A: bit 31 busy, bit 30 direction (1 = read), bit 29 timeout flag, bits 15:0 thread.
  - Command B: bits 31:28 byte enables, bits 15:0 word address.
  - Timeout control: bit 31 sticky flag, bits 15:0 period.
  - Unused bits read 0.
- R3: A write to command A with bit 31 set while idle starts a transaction. On the next cycle req_valid rises, carrying the direction, thread, address, byte enables and write data that were programmed. req_valid stays high until req_ready is sampled or the watchdog expires.
- R4: While busy, writes to command A, command B and write data are ignored. A command A write with bit 31 clear, made while idle, only updates the command A fields and does not start a request.
- R5: Busy clears at the clock edge where a response pulse is sampled after the request was accepted. Each transaction issues exactly one request.
- R6: A read response loads rsp_rdata into the read data register. A write response leaves that register unchanged.
- R7: With a period P (P = 0 is taken as 1), busy lasts at most max(P,1) cycles after the launch edge. At that edge, a missing response closes the transaction and sets both command A bit 29 and timeout control bit 31.
- R8: A response sampled on the same edge as the expiry counts as a normal completion. A response that comes after a timeout is discarded and does not change the read data register.
- R9: Timeout control bit 31 stays set until the host writes that register with bit 31 = 0. The command A timeout flag takes the value that the host writes in bit 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe |
| host_addr | input | 12 | Register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| req_valid | output | 1 | Request valid toward remote thread |
| req_ready | input | 1 | Remote accepts request |
| req_dir | output | 1 | 1 = read, 0 = write |
| req_thread | output | 16 | Target thread number |
| req_addr | output | 16 | Word address in thread configuration space |
| req_byten | output | 4 | Byte enables |
| req_wdata | output | 32 | Data for write requests |
| rsp_valid | input | 1 | One-cycle response pulse |
| rsp_rdata | input | 32 | Read data carried with the response |

## Verification
The timing rules that the bench relies on are:
- Register read data is due one edge after the read strobe.
- req_valid is due one edge after the launching write.
- The remote model accepts the request d cycles later and responds s cycles after acceptance. Busy therefore ends at edge 1+d+s after launch, or at edge max(P,1) when that comes first.

The bench issues one command A read every cycle right after launch and counts how many of them still report busy. That count must equal min(1+d+s, max(P,1)). The timeout flags, the read data register and the captured request fields are compared only after the remote model has gone idle, so a late response has already had its chance to corrupt state.

// File: rtl/cfg_xact_pkg.sv
package cfg_xact_pkg;
  localparam int unsigned OFS_W  = 12;
  localparam int unsigned WORD_W = 32;

  localparam logic [OFS_W-1:0] OFS_REV  = 12'h000;
  localparam logic [OFS_W-1:0] OFS_TMO  = 12'h010;
  localparam logic [OFS_W-1:0] OFS_CMDA = 12'h100;
  localparam logic [OFS_W-1:0] OFS_CMDB = 12'h104;
  localparam logic [OFS_W-1:0] OFS_WDAT = 12'h108;
  localparam logic [OFS_W-1:0] OFS_RDAT = 12'h140;

  localparam logic [WORD_W-1:0] REV_WORD = 32'h66C0_0100;

  localparam int unsigned BIT_BUSY  = 31;
  localparam int unsigned BIT_DIR   = 30;
  localparam int unsigned BIT_TOF   = 29;
  localparam int unsigned BIT_GFLAG = 31;
  localparam int unsigned BE_LSB    = 28;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } xact_state_e;
endpackage

// File: rtl/cfg_xact_wdog.sv
module cfg_xact_wdog #(
  parameter int unsigned PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period,
  output logic                expire
);
  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  logic [PERIOD_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (period == '0) ? ONE : period;
    end else if (run && (cnt_q > ONE)) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign expire = run && (cnt_q == ONE);

  // counter is never empty while a transaction is open (R7)
  assert_cnt_live_R7: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q != '0));
endmodule

// File: rtl/cfg_xact_seq.sv
module cfg_xact_seq
  import cfg_xact_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic req_ready,
  input  logic rsp_valid,
  input  logic expire,
  output logic busy,
  output logic req_valid,
  output logic xact_ok,
  output logic xact_tmo
);
  xact_state_e state_q;
  logic        req_valid_q;

  always_comb begin
    xact_ok  = (state_q == ST_WAIT) && rsp_valid;
    xact_tmo = expire && !xact_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      req_valid_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (launch) begin
          state_q     <= ST_REQ;
          req_valid_q <= 1'b1;
        end
        ST_REQ: if (xact_tmo) begin
          state_q     <= ST_IDLE;
          req_valid_q <= 1'b0;
        end else if (req_ready) begin
          state_q     <= ST_WAIT;
          req_valid_q <= 1'b0;
        end
        ST_WAIT: if (xact_ok || xact_tmo) begin
          state_q <= ST_IDLE;
        end
        default: begin
          state_q     <= ST_IDLE;
          req_valid_q <= 1'b0;
        end
      endcase
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign req_valid = req_valid_q;

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !expire) |=> req_valid);

  assert_single_req_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_valid);

  assert_close_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (xact_ok || xact_tmo) |=> !busy);
endmodule

// File: rtl/cfg_xact_regs.sv
module cfg_xact_regs
  import cfg_xact_pkg::*;
#(
  parameter int unsigned THREAD_W   = 16,
  parameter int unsigned WADDR_W    = 16,
  parameter int unsigned BE_W       = 4,
  parameter int unsigned PERIOD_W   = 16,
  parameter int unsigned RST_PERIOD = 1024
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_wr_en,
  input  logic                host_rd_en,
  input  logic [OFS_W-1:0]    host_addr,
  input  logic [WORD_W-1:0]   host_wdata,
  output logic [WORD_W-1:0]   host_rdata,
  input  logic                busy,
  input  logic                xact_ok,
  input  logic                xact_tmo,
  input  logic [WORD_W-1:0]   rsp_rdata,
  output logic                launch,
  output logic [PERIOD_W-1:0] period,
  output logic                cmd_dir,
  output logic [THREAD_W-1:0] cmd_thread,
  output logic [WADDR_W-1:0]  cmd_addr,
  output logic [BE_W-1:0]     cmd_byten,
  output logic [WORD_W-1:0]   cmd_wdata
);
  logic [PERIOD_W-1:0] period_q;
  logic                gflag_q, tof_q, dir_q;
  logic [THREAD_W-1:0] thread_q;
  logic [WADDR_W-1:0]  addr_q;
  logic [BE_W-1:0]     byten_q;
  logic [WORD_W-1:0]   wdata_q, rdata_q, host_rdata_q, rd_word;
  logic                wr_tmo, wr_cmda, wr_cmdb, wr_wdat;
  logic                unused_bits;

  assign unused_bits = ^host_wdata;

  always_comb begin
    wr_tmo  = host_wr_en && (host_addr == OFS_TMO);
    wr_cmda = host_wr_en && (host_addr == OFS_CMDA) && !busy;
    wr_cmdb = host_wr_en && (host_addr == OFS_CMDB) && !busy;
    wr_wdat = host_wr_en && (host_addr == OFS_WDAT) && !busy;
    launch  = wr_cmda && host_wdata[BIT_BUSY];
  end

  always_comb begin
    rd_word = '0;
    case (host_addr)
      OFS_REV:  rd_word = REV_WORD;
      OFS_TMO: begin
        rd_word[BIT_GFLAG]      = gflag_q;
        rd_word[PERIOD_W-1:0]   = period_q;
      end
      OFS_CMDA: begin
        rd_word[BIT_BUSY]       = busy;
        rd_word[BIT_DIR]        = dir_q;
        rd_word[BIT_TOF]        = tof_q;
        rd_word[THREAD_W-1:0]   = thread_q;
      end
      OFS_CMDB: begin
        rd_word[BE_LSB +: BE_W] = byten_q;
        rd_word[WADDR_W-1:0]    = addr_q;
      end
      OFS_WDAT: rd_word = wdata_q;
      OFS_RDAT: rd_word = rdata_q;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q     <= PERIOD_W'(RST_PERIOD);
      gflag_q      <= 1'b0;
      tof_q        <= 1'b0;
      dir_q        <= 1'b0;
      thread_q     <= '0;
      addr_q       <= '0;
      byten_q      <= '0;
      wdata_q      <= '0;
      rdata_q      <= '0;
      host_rdata_q <= '0;
    end else begin
      if (wr_tmo) period_q <= host_wdata[PERIOD_W-1:0];
      if (xact_tmo)    gflag_q <= 1'b1;
      else if (wr_tmo) gflag_q <= host_wdata[BIT_GFLAG];
      if (xact_tmo)     tof_q <= 1'b1;
      else if (wr_cmda) tof_q <= host_wdata[BIT_TOF];
      if (wr_cmda) begin
        dir_q    <= host_wdata[BIT_DIR];
        thread_q <= host_wdata[THREAD_W-1:0];
      end
      if (wr_cmdb) begin
        byten_q <= host_wdata[BE_LSB +: BE_W];
        addr_q  <= host_wdata[WADDR_W-1:0];
      end
      if (wr_wdat) wdata_q <= host_wdata;
      if (xact_ok && dir_q) rdata_q <= rsp_rdata;
      if (host_rd_en) host_rdata_q <= rd_word;
    end
  end

  assign host_rdata = host_rdata_q;
  assign period     = period_q;
  assign cmd_dir    = dir_q;
  assign cmd_thread = thread_q;
  assign cmd_addr   = addr_q;
  assign cmd_byten  = byten_q;
  assign cmd_wdata  = wdata_q;

  assert_cmd_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable({dir_q, thread_q, addr_q, byten_q, wdata_q}));

  assert_gflag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (gflag_q && !(host_wr_en && (host_addr == OFS_TMO) && !host_wdata[BIT_GFLAG]))
      |=> gflag_q);

  assert_tmo_flags_R7: assert property (@(posedge clk) disable iff (rst)
    xact_tmo |=> (gflag_q && tof_q));
endmodule

// File: rtl/cfg_xact_proxy.sv
module cfg_xact_proxy
  import cfg_xact_pkg::*;
#(
  parameter int unsigned THREAD_W   = 16,
  parameter int unsigned WADDR_W    = 16,
  parameter int unsigned BE_W       = 4,
  parameter int unsigned PERIOD_W   = 16,
  parameter int unsigned RST_PERIOD = 1024
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_wr_en,
  input  logic                host_rd_en,
  input  logic [OFS_W-1:0]    host_addr,
  input  logic [WORD_W-1:0]   host_wdata,
  output logic [WORD_W-1:0]   host_rdata,
  output logic                req_valid,
  input  logic                req_ready,
  output logic                req_dir,
  output logic [THREAD_W-1:0] req_thread,
  output logic [WADDR_W-1:0]  req_addr,
  output logic [BE_W-1:0]     req_byten,
  output logic [WORD_W-1:0]   req_wdata,
  input  logic                rsp_valid,
  input  logic [WORD_W-1:0]   rsp_rdata
);
  logic                busy, launch, xact_ok, xact_tmo, expire;
  logic [PERIOD_W-1:0] period;

  cfg_xact_regs #(
    .THREAD_W(THREAD_W), .WADDR_W(WADDR_W), .BE_W(BE_W),
    .PERIOD_W(PERIOD_W), .RST_PERIOD(RST_PERIOD)
  ) regs_i (
    .clk(clk), .rst(rst),
    .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .xact_ok(xact_ok), .xact_tmo(xact_tmo), .rsp_rdata(rsp_rdata),
    .launch(launch), .period(period),
    .cmd_dir(req_dir), .cmd_thread(req_thread), .cmd_addr(req_addr),
    .cmd_byten(req_byten), .cmd_wdata(req_wdata)
  );

  cfg_xact_seq seq_i (
    .clk(clk), .rst(rst), .launch(launch), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .expire(expire), .busy(busy),
    .req_valid(req_valid), .xact_ok(xact_ok), .xact_tmo(xact_tmo)
  );

  cfg_xact_wdog #(.PERIOD_W(PERIOD_W)) wdog_i (
    .clk(clk), .rst(rst), .load(launch), .run(busy),
    .period(period), .expire(expire)
  );
endmodule

// File: tb/cfg_xact_proxy_tb_top.sv
`timescale 1ns/1ps
module cfg_xact_proxy_tb_top;
  localparam logic [11:0] A_REV = 12'h000, A_TMO = 12'h010, A_CMDA = 12'h100,
                          A_CMDB = 12'h104, A_WDAT = 12'h108, A_RDAT = 12'h140;

  logic        clk = 1'b0, rst = 1'b1;
  logic        host_wr_en = 0, host_rd_en = 0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic        req_valid, req_ready, req_dir, rsp_valid;
  logic [15:0] req_thread, req_addr;
  logic [3:0]  req_byten;
  logic [31:0] req_wdata, rsp_rdata;

  always #2.5 clk = ~clk;

  cfg_xact_proxy dut_i (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_dir(req_dir),
    .req_thread(req_thread), .req_addr(req_addr), .req_byten(req_byten),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_data(logic [15:0] th, logic [15:0] ad);
    return {th ^ 16'h5A3C, ad ^ 16'hC3A5};
  endfunction

  task automatic hwr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); host_wr_en = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1 host_wr_en = 0;
  endtask

  task automatic hrd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); host_rd_en = 1; host_addr = a;
    @(posedge clk); #1 host_rd_en = 0; d = host_rdata;
  endtask

  // remote thread model
  int  m_rdy_dly = 0, m_rsp_dly = 1, m_reqs = 0;
  bit  m_respond = 1, m_active = 0, m_abort = 0;
  logic        cap_dir;
  logic [15:0] cap_thread, cap_addr;
  logic [3:0]  cap_be;
  logic [31:0] cap_wd;

  initial begin
    req_ready = 0; rsp_valid = 0; rsp_rdata = '0;
    forever begin
      @(negedge clk);
      if (req_valid) begin
        m_active = 1; m_abort = 0;
        for (int i = 0; i < m_rdy_dly; i++) begin
          @(negedge clk);
          if (!req_valid) begin m_abort = 1; break; end
        end
        if (!m_abort) begin
          req_ready = 1; m_reqs++;
          cap_dir = req_dir; cap_thread = req_thread; cap_addr = req_addr;
          cap_be = req_byten; cap_wd = req_wdata;
          @(negedge clk); req_ready = 0;
          if (m_respond) begin
            for (int i = 1; i < m_rsp_dly; i++) @(negedge clk);
            rsp_valid = 1; rsp_rdata = model_data(cap_thread, cap_addr);
            @(negedge clk); rsp_valid = 0;
          end
        end
        m_active = 0;
      end
    end
  end

  task automatic wait_model_idle();
    for (int i = 0; i < 3; i++) @(negedge clk);
    while (m_active) @(negedge clk);
    for (int i = 0; i < 2; i++) @(negedge clk);
  endtask

  task automatic poll(output int cnt, output logic [31:0] cmda);
    logic [31:0] d;
    cnt = 0; d = '0;
    for (int k = 0; k < 5000; k++) begin
      hrd(A_CMDA, d);
      if (!d[31]) break;
      cnt++;
    end
    cmda = d;
  endtask

  bit          g_exp = 0;
  logic [31:0] rd_exp = '0;

  task automatic xact(bit dir, logic [15:0] th, logic [15:0] ad, logic [3:0] be,
                      logic [31:0] wd, logic [15:0] per, int rdl, int sdl, bit resp);
    int cnt, lat, pe, exp_cnt, reqs0;
    bit exp_to;
    logic [31:0] cmda, d;
    hwr(A_TMO, {g_exp, 15'b0, per});
    hwr(A_CMDB, {be, 12'b0, ad});
    hwr(A_WDAT, wd);
    m_rdy_dly = rdl; m_rsp_dly = sdl; m_respond = resp; reqs0 = m_reqs;
    hwr(A_CMDA, {1'b1, dir, 1'b0, 13'b0, th});
    poll(cnt, cmda);
    lat = 1 + rdl + sdl;
    pe = (per == 0) ? 1 : int'(per);
    exp_to = !resp || (lat > pe);
    exp_cnt = exp_to ? pe : lat;
    chk("R5/R7 busy cycles", cnt, exp_cnt);
    chk("R7/R8 cmdA timeout flag", {31'b0, cmda[29]}, {31'b0, exp_to});
    chk("R2 cmdA fields", {16'b0, cmda[30], cmda[15:0]} & 32'h1FFFF, {15'b0, dir, th});
    wait_model_idle();
    if (1 + rdl <= pe) begin
      chk("R3/R5 one request", m_reqs - reqs0, 1);
      chk("R3 request fields", {cap_dir, cap_be, cap_thread[10:0], cap_addr},
          {dir, be, th[10:0], ad});
      if (!dir) chk("R3 write data", cap_wd, wd);
    end
    if (dir && !exp_to) rd_exp = model_data(th, ad);
    hrd(A_RDAT, d);
    chk("R6/R8 read data reg", d, rd_exp);
    if (exp_to) g_exp = 1;
    hrd(A_TMO, d);
    chk("R9 global flag", d, {g_exp, 15'b0, per});
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    int c;
    logic [31:0] cm;
    void'($urandom(32'h00C0FFEE));
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset values, R2 registered read
    hrd(A_REV, d);  chk("R1 revision", d, 32'h66C00100);
    hrd(A_TMO, d);  chk("R1 timeout ctrl", d, 32'h00000400);
    hrd(A_CMDA, d); chk("R1 cmdA", d, 32'h0);
    hrd(A_CMDB, d); chk("R1 cmdB", d, 32'h0);
    hrd(A_WDAT, d); chk("R1 wdata", d, 32'h0);
    hrd(A_RDAT, d); chk("R1 rdata", d, 32'h0);
    hrd(12'h020, d); chk("R1 reserved offset", d, 32'h0);

    // R4 idle cmdA write without busy: fields only, no request
    c = m_reqs;
    hwr(A_CMDA, {1'b0, 1'b1, 1'b1, 13'h1FFF, 16'hBEEF});
    repeat (3) @(negedge clk);
    hrd(A_CMDA, d); chk("R4/R2 cmdA no launch", d, 32'h6000BEEF);
    chk("R4 no request", m_reqs - c, 0);
    hwr(A_CMDA, 32'h0);
    hwr(A_CMDB, 32'hFFFF_FFFF);
    hrd(A_CMDB, d); chk("R2 cmdB layout", d, 32'hF000FFFF);

    // directed corners
    xact(1, 16'h0011, 16'h0002, 4'hF, 32'h0, 16'd4, 0, 3, 1);   // R8 response at expiry edge
    xact(0, 16'h0012, 16'h0040, 4'h3, 32'hCAFEF00D, 16'd0, 0, 1, 0); // R7 period 0 -> 1
    xact(1, 16'h0013, 16'h0400, 4'hF, 32'h0, 16'd3, 2, 1, 1);   // R8 late response dropped
    xact(0, 16'h0014, 16'h0001, 4'h5, 32'h12345678, 16'd9, 1, 2, 1); // R6 write keeps rdata
    xact(1, 16'h0015, 16'h0003, 4'hF, 32'h0, 16'd2, 5, 1, 1);   // R7 timeout in request phase

    // R4 writes ignored while busy
    hwr(A_TMO, {g_exp, 15'b0, 16'd30});
    hwr(A_CMDB, {4'hA, 12'b0, 16'h0123});
    hwr(A_WDAT, 32'h11112222);
    m_rdy_dly = 0; m_respond = 0;
    hwr(A_CMDA, {1'b1, 1'b0, 1'b0, 13'b0, 16'h0042});
    hwr(A_CMDB, {4'h5, 12'b0, 16'h0999});
    hwr(A_WDAT, 32'hDEADBEEF);
    hwr(A_CMDA, {1'b1, 1'b1, 1'b0, 13'b0, 16'h0077});
    poll(c, cm);
    wait_model_idle();
    g_exp = 1;
    hrd(A_CMDB, d); chk("R4 cmdB frozen", d, 32'hA0000123);
    hrd(A_WDAT, d); chk("R4 wdata frozen", d, 32'h11112222);
    hrd(A_CMDA, d); chk("R4 cmdA frozen", d, 32'h20000042);
    chk("R4 request thread", {16'b0, cap_thread}, 32'h42);

    // R9 clear of global flag
    hwr(A_TMO, {1'b0, 15'b0, 16'd20});
    g_exp = 0;
    hrd(A_TMO, d); chk("R9 flag cleared", d, 32'h00000014);

    // random mix
    for (int n = 0; n < 40; n++) begin
      if (n % 7 == 6) begin
        hwr(A_TMO, 32'h0000_0400);
        g_exp = 0;
      end
      xact(1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom), 4'($urandom),
           $urandom, 16'($urandom_range(0, 9)), int'($urandom_range(0, 3)),
           int'($urandom_range(1, 4)), ($urandom_range(0, 4) != 0));
    end

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule